// File: doc/BRIEF.md
# Dual-Issue Pairing Arbiter

This block sits at the end of a two-wide in-order issue stage. Each cycle it looks at the older instruction (slot 0) and the younger instruction (slot 1). It decides whether slot 0 issues, and whether slot 1 may go out in the same cycle. Slot 0 is never held back by slot 1. Slot 1 carries extra restrictions that come from pairing: a dependence on slot 0's result, a clash over a functional unit, a shared write-back bus, and speculation after a branch.

Each slot arrives with a unit type, its register indices and a single-slot readiness flag. The readiness flag already folds in the scoreboard hazards and unit-busy checks for that slot alone. The block also receives the branch kind of slot 0 and whether each of the two ALUs (primary and secondary) is free. The primary ALU shares one result bus with the branch unit and the CSR unit. The secondary ALU has a bus of its own.

The outputs are purely combinational. There is one issue enable per slot, and one ALU select per slot that says which ALU the slot uses.

Top module: `pair_issue_arbiter`

## Requirements
- R1: Slot 0 issues exactly when it is valid and ready and, for an ALU instruction, at least one ALU is free. The ALU code is listed in R7.
- R2: Slot 1 issues only in a cycle in which slot 0 issues, and only when slot 1 is itself valid and ready.
- R3: Slot 1 does not issue when any of its source registers equals slot 0's nonzero destination. No value is forwarded between the slots.
- R4: Slot 1 does not issue when its destination equals slot 0's nonzero destination.
- R5: Slot 1 never issues a CSR instruction. The CSR code is listed in R7.
- R6: When slot 0 issues a CSR instruction, slot 1 does not issue, whatever its unit.
- R7: Unit codes are 0 none, 1 ALU, 2 branch, 3 CSR, 4 multiplier, 5 load/store and 6 floating point. Slot 1 does not issue to the same non-ALU unit that slot 0 issues to.
- R8: The primary ALU, branch and CSR units share one result bus. Slot 1 may use that bus only if slot 0 does not. A slot 1 ALU instruction may still go to the secondary ALU if slot 0 leaves it free.
- R9: An ALU select of 1 means the secondary ALU and 0 means the primary ALU. The select reads 0 for a slot that does not issue an ALU instruction. A slot 0 ALU instruction takes the secondary ALU whenever it is free. Slot 1 takes whichever ALU slot 0 left, preferring the secondary.
- R10: When slot 0 issues a branch that is not a direct jump-and-link, slot 1 does not issue a load/store instruction. After a direct jump-and-link it may.
- R11: A slot 0 destination of register 0 never blocks slot 1 through R3 or R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s0_valid_i | input | 1 | Slot 0 holds an instruction |
| s0_ready_i | input | 1 | Slot 0 passes its own hazard checks |
| s0_unit_i | input | 3 | Slot 0 unit code |
| s0_rd_i | input | REG_W | Slot 0 destination register |
| s0_direct_jump_i | input | 1 | Slot 0 branch is a direct jump-and-link |
| s1_valid_i | input | 1 | Slot 1 holds an instruction |
| s1_ready_i | input | 1 | Slot 1 passes its own hazard checks |
| s1_unit_i | input | 3 | Slot 1 unit code |
| s1_src_i | input | NUM_SRC*REG_W | Slot 1 source registers |
| s1_rd_i | input | REG_W | Slot 1 destination register |
| alu_pri_free_i | input | 1 | Primary ALU can accept work |
| alu_sec_free_i | input | 1 | Secondary ALU can accept work |
| s0_issue_o | output | 1 | Slot 0 issues this cycle |
| s1_issue_o | output | 1 | Slot 1 issues this cycle |
| s0_alu_sec_o | output | 1 | Slot 0 uses the secondary ALU |
| s1_alu_sec_o | output | 1 | Slot 1 uses the secondary ALU |

## Verification
The hardest case to reach from the ports is a slot 1 ALU instruction. Whether it issues depends on three things together: which ALUs are free, which ALU slot 0 claimed, and whether slot 0 is already on the shared result bus. A pair that issues with both ALUs free can block once only one ALU is free.

The vector table therefore walks the four combinations of ALU availability. It crosses them with slot 0 on an ALU, on a branch and on a non-ALU unit, so that each route slot 1 can take is seen to open and to close. Cases for register 0 and for a direct jump-and-link against an ordinary branch are set beside the register-hazard cases that would otherwise block.

// File: rtl/pair_pkg.sv
package pair_pkg;
    localparam int UNIT_W = 3;

    typedef enum logic [UNIT_W-1:0] {
        FU_NONE   = 3'd0,
        FU_ALU    = 3'd1,
        FU_BRANCH = 3'd2,
        FU_CSR    = 3'd3,
        FU_MULT   = 3'd4,
        FU_LSU    = 3'd5,
        FU_FPU    = 3'd6
    } fu_e;

    typedef struct packed {
        logic s0_go;
        logic s0_sec;
        logic sec_left;
        logic pri_left;
        logic bus_busy;
    } steer_t;
endpackage

// File: rtl/pair_dep_check.sv
module pair_dep_check #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [REG_W-1:0]              prod_rd_i,
    input  logic [NUM_SRC-1:0][REG_W-1:0] cons_src_i,
    input  logic [REG_W-1:0]              cons_rd_i,
    output logic                          raw_o,
    output logic                          waw_o
);
    logic             prod_live;
    logic [NUM_SRC-1:0] src_hit;

    assign prod_live = |prod_rd_i;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src_hit[g] = prod_live && (cons_src_i[g] == prod_rd_i);
    end

    assign raw_o = |src_hit;
    assign waw_o = prod_live && (cons_rd_i == prod_rd_i);

    always_comb begin
        AST_X0_NO_DEP: assert (!((raw_o || waw_o) && (prod_rd_i == '0))); // R11
    end
endmodule

// File: rtl/pair_alu_steer.sv
module pair_alu_steer
    import pair_pkg::*;
(
    input  logic              s0_req_i,
    input  logic [UNIT_W-1:0] s0_unit_i,
    input  logic              pri_free_i,
    input  logic              sec_free_i,
    output steer_t            steer_o
);
    steer_t steer_d;
    logic   s0_alu;

    always_comb begin
        s0_alu           = (s0_unit_i == FU_ALU);
        steer_d.s0_sec   = s0_alu && sec_free_i;
        steer_d.s0_go    = s0_req_i && (!s0_alu || pri_free_i || sec_free_i);
        steer_d.sec_left = sec_free_i && !(steer_d.s0_go && s0_alu && steer_d.s0_sec);
        steer_d.pri_left = pri_free_i && !(steer_d.s0_go && s0_alu && !steer_d.s0_sec);
        steer_d.bus_busy = steer_d.s0_go &&
                           ((s0_alu && !steer_d.s0_sec) ||
                            (s0_unit_i == FU_BRANCH) || (s0_unit_i == FU_CSR));
    end

    assign steer_o = steer_d;

    always_comb begin
        AST_PREFER_SEC: assert (!(steer_d.s0_go && s0_alu && sec_free_i && !steer_d.s0_sec)); // R9
    end
endmodule

// File: rtl/pair_unit_check.sv
module pair_unit_check
    import pair_pkg::*;
(
    input  logic              s0_go_i,
    input  logic [UNIT_W-1:0] s0_unit_i,
    input  logic              s0_direct_jump_i,
    input  logic [UNIT_W-1:0] s1_unit_i,
    input  logic              alu_route_i,
    input  logic              bus_busy_i,
    output logic              s1_unit_ok_o
);
    logic kind_ok;
    logic same_unit;
    logic csr_solo;
    logic spec_branch;

    always_comb begin
        spec_branch = s0_go_i && (s0_unit_i == FU_BRANCH) && !s0_direct_jump_i;
        same_unit   = s0_go_i && (s0_unit_i == s1_unit_i) &&
                      (s1_unit_i != FU_NONE) && (s1_unit_i != FU_ALU);
        csr_solo    = s0_go_i && (s0_unit_i == FU_CSR);
        unique case (s1_unit_i)
            FU_NONE:   kind_ok = 1'b1;
            FU_ALU:    kind_ok = alu_route_i;
            FU_BRANCH: kind_ok = !bus_busy_i;
            FU_CSR:    kind_ok = 1'b0;
            FU_LSU:    kind_ok = !spec_branch;
            default:   kind_ok = 1'b1;
        endcase
        s1_unit_ok_o = kind_ok && !same_unit && !csr_solo;
    end

    always_comb begin
        AST_BRANCH_BUS: assert (!(s1_unit_ok_o && (s1_unit_i == FU_BRANCH) && bus_busy_i)); // R8
    end
endmodule

// File: rtl/pair_issue_arbiter.sv
module pair_issue_arbiter
    import pair_pkg::*;
#(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                          s0_valid_i,
    input  logic                          s0_ready_i,
    input  logic [UNIT_W-1:0]             s0_unit_i,
    input  logic [REG_W-1:0]              s0_rd_i,
    input  logic                          s0_direct_jump_i,
    input  logic                          s1_valid_i,
    input  logic                          s1_ready_i,
    input  logic [UNIT_W-1:0]             s1_unit_i,
    input  logic [NUM_SRC-1:0][REG_W-1:0] s1_src_i,
    input  logic [REG_W-1:0]              s1_rd_i,
    input  logic                          alu_pri_free_i,
    input  logic                          alu_sec_free_i,
    output logic                          s0_issue_o,
    output logic                          s1_issue_o,
    output logic                          s0_alu_sec_o,
    output logic                          s1_alu_sec_o
);
    steer_t steer;
    logic   raw_hit;
    logic   waw_hit;
    logic   unit_ok;
    logic   alu_route;

    pair_alu_steer u_steer (
        .s0_req_i   (s0_valid_i && s0_ready_i),
        .s0_unit_i  (s0_unit_i),
        .pri_free_i (alu_pri_free_i),
        .sec_free_i (alu_sec_free_i),
        .steer_o    (steer)
    );

    pair_dep_check #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_dep (
        .prod_rd_i  (s0_rd_i),
        .cons_src_i (s1_src_i),
        .cons_rd_i  (s1_rd_i),
        .raw_o      (raw_hit),
        .waw_o      (waw_hit)
    );

    assign alu_route = steer.sec_left || (steer.pri_left && !steer.bus_busy);

    pair_unit_check u_unit (
        .s0_go_i          (steer.s0_go),
        .s0_unit_i        (s0_unit_i),
        .s0_direct_jump_i (s0_direct_jump_i),
        .s1_unit_i        (s1_unit_i),
        .alu_route_i      (alu_route),
        .bus_busy_i       (steer.bus_busy),
        .s1_unit_ok_o     (unit_ok)
    );

    always_comb begin
        s0_issue_o   = steer.s0_go;
        s0_alu_sec_o = steer.s0_go && steer.s0_sec;
        s1_issue_o   = steer.s0_go && s1_valid_i && s1_ready_i &&
                       !raw_hit && !waw_hit && unit_ok;
        s1_alu_sec_o = s1_issue_o && (s1_unit_i == FU_ALU) && steer.sec_left;
    end

    always_comb begin
        AST_S1_NEEDS_S0: assert (!(s1_issue_o && !s0_issue_o)); // R2
        AST_S1_NO_CSR: assert (!(s1_issue_o && (s1_unit_i == FU_CSR))); // R5
        AST_CSR_SOLO: assert (!(s1_issue_o && (s0_unit_i == FU_CSR))); // R6
        AST_NO_RAW: assert (!(s1_issue_o && (s0_rd_i != '0) &&
                             ((s1_src_i[0] == s0_rd_i) || (s1_src_i[NUM_SRC-1] == s0_rd_i)))); // R3
        AST_NO_WAW: assert (!(s1_issue_o && (s0_rd_i != '0) && (s1_rd_i == s0_rd_i))); // R4
        AST_LSU_SPEC: assert (!(s1_issue_o && (s1_unit_i == FU_LSU) &&
                               (s0_unit_i == FU_BRANCH) && !s0_direct_jump_i)); // R10
        AST_ONE_ALU_EACH: assert (!(s0_alu_sec_o && s1_alu_sec_o)); // R9
    end
endmodule

// File: tb/sim_pair_issue_arbiter.sv
module sim_pair_issue_arbiter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       s0_valid = 0, s0_ready = 0, s0_jal = 0;
    logic [2:0] s0_unit = 0, s1_unit = 0;
    logic [4:0] s0_rd = 0, s1_rd = 0;
    logic       s1_valid = 0, s1_ready = 0;
    logic [1:0][4:0] s1_src = '0;
    logic       a_pri = 0, a_sec = 0;
    logic       s0_iss, s1_iss, s0_sec, s1_sec;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    pair_issue_arbiter u0 (
        .s0_valid_i(s0_valid), .s0_ready_i(s0_ready), .s0_unit_i(s0_unit),
        .s0_rd_i(s0_rd), .s0_direct_jump_i(s0_jal),
        .s1_valid_i(s1_valid), .s1_ready_i(s1_ready), .s1_unit_i(s1_unit),
        .s1_src_i(s1_src), .s1_rd_i(s1_rd),
        .alu_pri_free_i(a_pri), .alu_sec_free_i(a_sec),
        .s0_issue_o(s0_iss), .s1_issue_o(s1_iss),
        .s0_alu_sec_o(s0_sec), .s1_alu_sec_o(s1_sec)
    );

    typedef struct packed {
        logic [3:0] req;
        logic s0v; logic s0r; logic [2:0] s0u; logic [4:0] s0d; logic jal;
        logic s1v; logic s1r; logic [2:0] s1u; logic [4:0] r1; logic [4:0] r2; logic [4:0] s1d;
        logic ap; logic as;
        logic e0; logic e1; logic e0s; logic e1s;
    } vec_t;

    localparam int NV = 22;
    // units: 0 none 1 alu 2 branch 3 csr 4 mult 5 lsu 6 fpu
    localparam vec_t VECS [NV] = '{
        '{9,  1,1,1,1,0, 1,1,1,2,3,4,   1,1, 1,1,1,0},  // R9 both free
        '{3,  1,1,1,5,0, 1,1,1,5,3,4,   1,1, 1,0,1,0},  // R3 rs1 match
        '{3,  1,1,4,7,0, 1,1,1,1,7,4,   1,1, 1,0,0,0},  // R3 rs2 match
        '{4,  1,1,5,9,0, 1,1,1,1,2,9,   1,1, 1,0,0,0},  // R4 same rd
        '{11, 1,1,1,0,0, 1,1,1,0,0,0,   1,1, 1,1,1,0},  // R11 x0
        '{5,  1,1,4,3,0, 1,1,3,1,2,4,   1,1, 1,0,0,0},  // R5 slot1 csr
        '{6,  1,1,3,3,0, 1,1,5,1,2,5,   1,1, 1,0,0,0},  // R6 slot0 csr
        '{7,  1,1,4,3,0, 1,1,4,1,2,5,   1,1, 1,0,0,0},  // R7 mult twice
        '{7,  1,1,5,3,0, 1,1,5,1,2,6,   1,1, 1,0,0,0},  // R7 lsu twice
        '{8,  1,1,2,0,0, 1,1,1,1,2,6,   1,0, 1,0,0,0},  // R8 branch, no sec
        '{8,  1,1,2,0,0, 1,1,1,1,2,6,   1,1, 1,1,0,1},  // R8 branch, sec free
        '{8,  1,1,1,3,0, 1,1,2,1,2,0,   1,0, 1,0,0,0},  // R8 alu on primary vs branch
        '{8,  1,1,1,3,0, 1,1,2,1,2,0,   1,1, 1,1,1,0},  // R8 alu on secondary vs branch
        '{10, 1,1,2,0,0, 1,1,5,1,2,4,   1,1, 1,0,0,0},  // R10 plain branch
        '{10, 1,1,2,1,1, 1,1,5,2,3,4,   1,1, 1,1,0,0},  // R10 jal
        '{2,  1,0,4,3,0, 1,1,5,1,2,4,   1,1, 0,0,0,0},  // R2 slot0 not ready
        '{2,  1,1,4,3,0, 1,0,5,1,2,4,   1,1, 1,0,0,0},  // R2 slot1 not ready
        '{1,  1,1,1,3,0, 1,1,6,1,2,4,   0,0, 0,0,0,0},  // R1 no alu free
        '{9,  1,1,1,3,0, 1,1,1,1,2,4,   0,1, 1,0,1,0},  // R9 only sec free
        '{9,  1,1,4,3,0, 1,1,1,1,2,4,   0,1, 1,1,0,1},  // R9 slot1 takes sec
        '{1,  0,1,4,3,0, 1,1,5,1,2,4,   1,1, 0,0,0,0},  // R1 slot0 invalid
        '{7,  1,1,2,0,0, 1,1,2,1,2,0,   1,1, 1,0,0,0}   // R7 branch twice
    };

    task automatic check(input string tag, input int idx, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s case %0d: got %0b expected %0b", tag, idx, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // idle state after reset: nothing issues (R1, R2)
        check("R1", -1, s0_iss, 1'b0);
        check("R2", -1, s1_iss, 1'b0);
        check("R9", -1, s0_sec | s1_sec, 1'b0);

        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            #1;
            s0_valid = VECS[i].s0v; s0_ready = VECS[i].s0r; s0_unit = VECS[i].s0u;
            s0_rd = VECS[i].s0d; s0_jal = VECS[i].jal;
            s1_valid = VECS[i].s1v; s1_ready = VECS[i].s1r; s1_unit = VECS[i].s1u;
            s1_src[0] = VECS[i].r1; s1_src[1] = VECS[i].r2; s1_rd = VECS[i].s1d;
            a_pri = VECS[i].ap; a_sec = VECS[i].as;
            @(negedge clk);
            check($sformatf("R%0d", VECS[i].req), i, s0_iss, VECS[i].e0);
            check($sformatf("R%0d", VECS[i].req), i, s1_iss, VECS[i].e1);
            check($sformatf("R%0d", VECS[i].req), i, s0_sec, VECS[i].e0s);
            check($sformatf("R%0d", VECS[i].req), i, s1_sec, VECS[i].e1s);
        end

        // R11 directed: source 0 against a slot 0 destination of 0, mult then fpu
        @(posedge clk); #1;
        s0_valid = 1; s0_ready = 1; s0_unit = 3'd4; s0_rd = 0; s0_jal = 0;
        s1_valid = 1; s1_ready = 1; s1_unit = 3'd6; s1_src[0] = 7; s1_src[1] = 0; s1_rd = 0;
        a_pri = 0; a_sec = 0;
        @(negedge clk);
        check("R11", 100, s1_iss, 1'b1);

        // R3 directed: same registers but slot 0 now writes register 7
        @(posedge clk); #1;
        s0_rd = 7;
        @(negedge clk);
        check("R3", 101, s1_iss, 1'b0);
        check("R1", 101, s0_iss, 1'b1);

        summary();
    end
endmodule